// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

A device-side mailbox that a host drives over a simple word-addressed register bus. The host fills in an opcode, an input length and a payload in a 256-byte payload RAM, then rings a doorbell bit. The block pulses a command-valid strobe to the device engine. While the doorbell is set, the host's view of the command is frozen. The device engine may read and write the payload RAM. It finishes by pulsing a done strobe that carries a return code and an output length, and that edge clears the doorbell.

A return code of 1 on completion means the command goes on in the background. The block then latches the opcode into a background status word and tracks a percent-complete value, which the device updates through a progress input. The background command is complete exactly when the percentage reaches 100. The final background return code is captured at that edge. If the host has enabled it, a one-cycle completion interrupt is raised at the same time. Any host write that the doorbell lockout rejects sets a sticky error flag.

Word map (word addresses): 0 control (bit0 doorbell, bit1 background-interrupt enable), 1 capability, 2 opcode [15:0], 3 length [20:0], 4 return code [15:0], 5 background status (opcode [15:0], percent [22:16]), 6 background return code [15:0], 7 lockout error (bit0), 128..191 payload words 0..63. Every other address reads as zero.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset, words 0, 2, 3, 4, 5, 6, 7 and every payload word read as zero. A host write to word 0 with bit0 = 1 while the doorbell is clear sets the doorbell and loads bit1 as the interrupt enable. A host write can never clear the doorbell; only an accepted done strobe does.
- R2: devCmdValid is high for exactly one cycle, the cycle after the clock edge that accepted a doorbell-ringing write.
- R3: While the doorbell is set, host writes to word 0, 2, 3 or to any payload word leave every register unchanged and set word 7 bit0. That flag stays set until the host writes word 7 with bit0 = 1. Writes to word 2 and 3 while the doorbell is clear load opcode [15:0] and length [20:0].
- R4: devDone while the doorbell is set clears the doorbell, loads word 4 with devRetCode and loads word 3 with devOutLen, all at one edge. devDone while the doorbell is clear changes nothing.
- R5: Device payload writes (devRamWe) take effect only while the doorbell is set. After completion, the payload, command and status words keep their values until the next doorbell.
- R6: The capability word reads bits [4:0] = 8 (a payload of 2^8 bytes), bit5 = 1 (completion interrupt supported) and bits [11:8] = 3 (interrupt message number), with all other bits 0.
- R7: A completion with return code 1 loads word 5 with the current opcode and percent 0, clears word 6, and marks a background command active.
- R8: While a background command is active, each devBgValid loads the percentage, clamped to 100. At 100, word 6 takes devBgRc and the command stops being active. Progress updates while no background command is active change nothing.
- R9: bgIrq is high for exactly one cycle, the cycle after the edge at which an accepted progress update reaches 100, and only if control bit1 was set. Otherwise it stays low.
- R10: Reads of payload-range addresses 192..255 and of unmapped addresses 8..127 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWr | input | 1 | Host write strobe |
| regAddr | input | 8 | Host word address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data for regAddr (combinational) |
| devCmdValid | output | 1 | One-cycle pulse: command handed to the device |
| devOpcode | output | 16 | Current opcode |
| devInLen | output | 21 | Current length field |
| devDone | input | 1 | Device completion strobe |
| devRetCode | input | 16 | Return code given with devDone |
| devOutLen | input | 21 | Output length given with devDone |
| devRamWe | input | 1 | Device payload write enable |
| devRamAddr | input | 6 | Device payload word index |
| devRamWdata | input | 32 | Device payload write data |
| devRamRdata | output | 32 | Payload word at devRamAddr |
| devBgValid | input | 1 | Background progress update strobe |
| devBgPct | input | 7 | Reported percent complete |
| devBgRc | input | 16 | Background return code, taken at 100 percent |
| bgIrq | output | 1 | Background completion interrupt pulse |

## Verification
A host write can land on the same edge as the device's done strobe. The lockout decision must then use the doorbell as it was before that edge. The bench provokes this by driving a control write and devDone together while the doorbell is set. It expects the write to be rejected with the error flag raised, and the doorbell to be cleared with the new status and length loaded. A behavioural model compares regRdata, devCmdValid and bgIrq on every clock, so a wrong priority shows up in the very cycle after the collision.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic ringDb;    // doorbell rung by an accepted host write
    logic doneDb;    // device completion accepted
    logic wrOpc;     // host opcode write accepted
    logic wrLen;     // host length write accepted
    logic wrRam;     // host payload write accepted
    logic devRam;    // device payload write accepted
    logic bgStart;   // completion asked for background execution
    logic bgUpdate;  // progress update accepted
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIDX   = 6,
  parameter int RC_W   = 16,
  parameter int PCT_W  = 7,
  parameter int RC_BG  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regWbits,
  input  logic              devDone,
  input  logic [RC_W-1:0]   devRetCode,
  input  logic              devRamWe,
  input  logic              devBgValid,
  input  logic [PCT_W-1:0]  devBgPct,
  output mbxStrobe_t        strobe,
  output logic              doorbell,
  output logic              irqEn,
  output logic              lockErr,
  output logic              cmdValid,
  output logic              bgIrq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(7);

  logic isCtrl, isOpc, isLen, isErr, isPay, guarded, lockHit, bgActive, pctFull;

  assign isCtrl  = regAddr == A_CTRL;
  assign isOpc   = regAddr == A_OPC;
  assign isLen   = regAddr == A_LEN;
  assign isErr   = regAddr == A_ERR;
  assign isPay   = regAddr[ADDR_W-1] && (regAddr[ADDR_W-2:WIDX] == '0);
  assign guarded = isCtrl || isOpc || isLen || isPay;
  assign lockHit = regWr && doorbell && guarded;
  assign pctFull = devBgPct >= PCT_W'(100);

  always_comb begin
    strobe          = '0;
    strobe.ringDb   = regWr && !doorbell && isCtrl && regWbits[0];
    strobe.doneDb   = devDone && doorbell;
    strobe.wrOpc    = regWr && !doorbell && isOpc;
    strobe.wrLen    = regWr && !doorbell && isLen;
    strobe.wrRam    = regWr && !doorbell && isPay;
    strobe.devRam   = devRamWe && doorbell;
    strobe.bgStart  = devDone && doorbell && (devRetCode == RC_W'(RC_BG));
    strobe.bgUpdate = devBgValid && bgActive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doorbell <= 1'b0;
      irqEn    <= 1'b0;
      lockErr  <= 1'b0;
      bgActive <= 1'b0;
      cmdValid <= 1'b0;
      bgIrq    <= 1'b0;
    end else begin
      if (strobe.ringDb) doorbell <= 1'b1;
      else if (strobe.doneDb) doorbell <= 1'b0;
      if (regWr && !doorbell && isCtrl) irqEn <= regWbits[1];
      if (lockHit) lockErr <= 1'b1;
      else if (regWr && isErr && regWbits[0]) lockErr <= 1'b0;
      if (strobe.bgStart) bgActive <= 1'b1;
      else if (strobe.bgUpdate && pctFull) bgActive <= 1'b0;
      cmdValid <= strobe.ringDb;
      bgIrq    <= strobe.bgUpdate && pctFull && irqEn;
    end
  end
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PAY_LOG2 = 8,
  parameter int OPC_W    = 16,
  parameter int LEN_W    = 21,
  parameter int RC_W     = 16,
  parameter int PCT_W    = 7,
  parameter int MSG_NUM  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  mbxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PAY_LOG2-3:0] devRamAddr,
  input  logic [DATA_W-1:0] devRamWdata,
  input  logic [RC_W-1:0]   devRetCode,
  input  logic [LEN_W-1:0]  devOutLen,
  input  logic [PCT_W-1:0]  devBgPct,
  input  logic [RC_W-1:0]   devBgRc,
  input  logic              doorbell,
  input  logic              irqEn,
  input  logic              lockErr,
  output logic [DATA_W-1:0] regRdata,
  output logic [OPC_W-1:0]  opcode,
  output logic [LEN_W-1:0]  lenField,
  output logic [DATA_W-1:0] devRamRdata
);
  localparam int WIDX      = PAY_LOG2 - 2;
  localparam int PAY_WORDS = 1 << WIDX;
  localparam logic [PCT_W-1:0] PCT_MAX = PCT_W'(100);

  logic [RC_W-1:0]   retCode, bgRc;
  logic [OPC_W-1:0]  bgOpc;
  logic [PCT_W-1:0]  bgPct, pctClamp;
  logic [DATA_W-1:0] ramRd [PAY_WORDS];
  logic              isPay;

  assign pctClamp = (devBgPct > PCT_MAX) ? PCT_MAX : devBgPct;
  assign isPay    = regAddr[ADDR_W-1] && (regAddr[ADDR_W-2:WIDX] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0; lenField <= '0; retCode <= '0;
      bgOpc <= '0; bgPct <= '0; bgRc <= '0;
    end else begin
      if (strobe.wrOpc) opcode <= regWdata[OPC_W-1:0];
      if (strobe.doneDb) begin
        lenField <= devOutLen;
        retCode  <= devRetCode;
      end else if (strobe.wrLen) begin
        lenField <= regWdata[LEN_W-1:0];
      end
      if (strobe.bgStart) begin
        bgOpc <= opcode; bgPct <= '0; bgRc <= '0;
      end else if (strobe.bgUpdate) begin
        bgPct <= pctClamp;
        if (pctClamp == PCT_MAX) bgRc <= devBgRc;
      end
    end
  end

  for (genvar i = 0; i < PAY_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst) word <= '0;
      else if (strobe.wrRam && regAddr[WIDX-1:0] == WIDX'(i)) word <= regWdata;
      else if (strobe.devRam && devRamAddr == WIDX'(i)) word <= devRamWdata;
    end
    assign ramRd[i] = word;
  end

  assign devRamRdata = ramRd[devRamAddr];

  always_comb begin
    regRdata = '0;
    if (isPay) begin
      regRdata = ramRd[regAddr[WIDX-1:0]];
    end else begin
      case (regAddr)
        ADDR_W'(0): regRdata[1:0] = {irqEn, doorbell};
        ADDR_W'(1): begin
          regRdata[4:0]  = 5'(PAY_LOG2);
          regRdata[5]    = 1'b1;
          regRdata[11:8] = 4'(MSG_NUM);
        end
        ADDR_W'(2): regRdata[OPC_W-1:0] = opcode;
        ADDR_W'(3): regRdata[LEN_W-1:0] = lenField;
        ADDR_W'(4): regRdata[RC_W-1:0]  = retCode;
        ADDR_W'(5): begin
          regRdata[OPC_W-1:0]       = bgOpc;
          regRdata[16+PCT_W-1:16]   = bgPct;
        end
        ADDR_W'(6): regRdata[RC_W-1:0]  = bgRc;
        ADDR_W'(7): regRdata[0]         = lockErr;
        default:    regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PAY_LOG2 = 8,
  parameter int OPC_W    = 16,
  parameter int LEN_W    = 21,
  parameter int RC_W     = 16,
  parameter int PCT_W    = 7,
  parameter int RC_BG    = 1,
  parameter int MSG_NUM  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                devCmdValid,
  output logic [OPC_W-1:0]    devOpcode,
  output logic [LEN_W-1:0]    devInLen,
  input  logic                devDone,
  input  logic [RC_W-1:0]     devRetCode,
  input  logic [LEN_W-1:0]    devOutLen,
  input  logic                devRamWe,
  input  logic [PAY_LOG2-3:0] devRamAddr,
  input  logic [DATA_W-1:0]   devRamWdata,
  output logic [DATA_W-1:0]   devRamRdata,
  input  logic                devBgValid,
  input  logic [PCT_W-1:0]    devBgPct,
  input  logic [RC_W-1:0]     devBgRc,
  output logic                bgIrq
);
  localparam int WIDX = PAY_LOG2 - 2;

  mbxStrobe_t strobe;
  logic doorbell, irqEn, lockErr;

  mbx_ctrl #(.ADDR_W(ADDR_W), .WIDX(WIDX), .RC_W(RC_W), .PCT_W(PCT_W), .RC_BG(RC_BG)) ctrl_i (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWbits(regWdata[1:0]),
    .devDone(devDone), .devRetCode(devRetCode), .devRamWe(devRamWe),
    .devBgValid(devBgValid), .devBgPct(devBgPct), .strobe(strobe),
    .doorbell(doorbell), .irqEn(irqEn), .lockErr(lockErr),
    .cmdValid(devCmdValid), .bgIrq(bgIrq)
  );

  mbx_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAY_LOG2(PAY_LOG2), .OPC_W(OPC_W),
             .LEN_W(LEN_W), .RC_W(RC_W), .PCT_W(PCT_W), .MSG_NUM(MSG_NUM)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .regAddr(regAddr), .regWdata(regWdata),
    .devRamAddr(devRamAddr), .devRamWdata(devRamWdata), .devRetCode(devRetCode),
    .devOutLen(devOutLen), .devBgPct(devBgPct), .devBgRc(devBgRc),
    .doorbell(doorbell), .irqEn(irqEn), .lockErr(lockErr),
    .regRdata(regRdata), .opcode(devOpcode), .lenField(devInLen),
    .devRamRdata(devRamRdata)
  );
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PCT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              devCmdValid,
  input logic              devDone,
  input logic              devBgValid,
  input logic [PCT_W-1:0]  devBgPct,
  input logic              bgIrq,
  input logic              doorbell,
  input logic              lockErr
);
  // R2
  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    devCmdValid |=> !devCmdValid);
  // R2
  p_cmd_cause_r2: assert property (@(posedge clk) disable iff (rst)
    devCmdValid |-> $past(regWr && regAddr == ADDR_W'(0) && regWdata[0]));
  // R9
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    bgIrq |=> !bgIrq);
  // R9
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    bgIrq |-> $past(devBgValid && devBgPct >= PCT_W'(100)));
  // R1, R4
  p_db_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(doorbell) && !doorbell) |-> $past(devDone));
  // R3
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(lockErr) && !lockErr) |-> $past(regWr && regAddr == ADDR_W'(7) && regWdata[0]));
endmodule

bind dbell_mailbox dbell_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PCT_W(PCT_W)) chk_i (
  .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .devCmdValid(devCmdValid), .devDone(devDone), .devBgValid(devBgValid),
  .devBgPct(devBgPct), .bgIrq(bgIrq), .doorbell(doorbell), .lockErr(lockErr)
);

// File: tb/dbell_mailbox_tb_top.sv
module dbell_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic regWr = 0; logic [7:0] regAddr = 0; logic [31:0] regWdata = 0;
  logic [31:0] regRdata, devRamRdata;
  logic devCmdValid, bgIrq;
  logic [15:0] devOpcode; logic [20:0] devInLen;
  logic devDone = 0; logic [15:0] devRetCode = 0; logic [20:0] devOutLen = 0;
  logic devRamWe = 0; logic [5:0] devRamAddr = 0; logic [31:0] devRamWdata = 0;
  logic devBgValid = 0; logic [6:0] devBgPct = 0; logic [15:0] devBgRc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_mailbox dut_i (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference state
  bit mDb, mEn, mErr, mAct, mCmdV, mIrq, oDb, oEn, oAct;
  logic [31:0] mOpc, mLen, mSt, mBgOpc, mBgPct, mBgRc;
  logic [31:0] mRam [64];
  int pTmp;

  function automatic logic [31:0] mRead(int a);
    if (a == 0) return {30'd0, mEn, mDb};
    if (a == 1) return 32'h0000_0328;
    if (a == 2) return mOpc;
    if (a == 3) return mLen;
    if (a == 4) return mSt;
    if (a == 5) return (mBgPct << 16) | mBgOpc;
    if (a == 6) return mBgRc;
    if (a == 7) return {31'd0, mErr};
    if (a >= 128 && a < 192) return mRam[a-128];
    return 32'd0;
  endfunction

  function automatic string tagOf(int a);
    if (a == 0) return "R1";
    if (a == 1) return "R6";
    if (a == 2 || a == 7) return "R3";
    if (a == 3 || a == 4) return "R4";
    if (a == 5 || a == 6) return "R8";
    if (a >= 128 && a < 192) return "R5";
    return "R10";
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mDb = 0; mEn = 0; mErr = 0; mAct = 0; mCmdV = 0; mIrq = 0;
      mOpc = 0; mLen = 0; mSt = 0; mBgOpc = 0; mBgPct = 0; mBgRc = 0;
      for (int i = 0; i < 64; i++) mRam[i] = 0;
    end else begin
      oDb = mDb; oEn = mEn; oAct = mAct;
      mCmdV = 0; mIrq = 0;
      if (regWr) begin
        if (regAddr == 0) begin
          if (oDb) mErr = 1; else begin mDb = regWdata[0]; mEn = regWdata[1]; mCmdV = regWdata[0]; end
        end else if (regAddr == 2) begin
          if (oDb) mErr = 1; else mOpc = regWdata & 32'hFFFF;
        end else if (regAddr == 3) begin
          if (oDb) mErr = 1; else mLen = regWdata & 32'h1F_FFFF;
        end else if (regAddr == 7) begin
          if (regWdata[0]) mErr = 0;
        end else if (regAddr >= 128 && regAddr < 192) begin
          if (oDb) mErr = 1; else mRam[regAddr-128] = regWdata;
        end
      end
      if (devRamWe && oDb) mRam[devRamAddr] = devRamWdata;
      if (devBgValid && oAct) begin
        pTmp = (devBgPct > 100) ? 100 : int'(devBgPct);
        mBgPct = pTmp;
        if (pTmp == 100) begin mBgRc = devBgRc; mAct = 0; mIrq = oEn; end
      end
      if (devDone && oDb) begin
        mDb = 0; mSt = devRetCode; mLen = devOutLen;
        if (devRetCode == 1) begin mBgOpc = mOpc; mBgPct = 0; mBgRc = 0; mAct = 1; end
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && !finished) begin
      chk(regRdata === mRead(regAddr), tagOf(regAddr), "model read", regRdata, mRead(regAddr));
      chk(devCmdValid === mCmdV, "R2", "model devCmdValid", 32'(devCmdValid), 32'(mCmdV));
      chk(bgIrq === mIrq, "R9", "model bgIrq", 32'(bgIrq), 32'(mIrq));
    end
  end

  task automatic hostWr(int a, logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = 8'(a); regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic expectRead(int a, logic [31:0] exp, string tag);
    @(negedge clk); regAddr = 8'(a); #1;
    chk(regRdata === exp, tag, $sformatf("read word %0d", a), regRdata, exp);
  endtask

  task automatic devFinish(logic [15:0] rc, logic [20:0] len);
    @(negedge clk); devDone = 1; devRetCode = rc; devOutLen = len;
    @(negedge clk); devDone = 0;
  endtask

  task automatic devRam(int idx, logic [31:0] d);
    @(negedge clk); devRamWe = 1; devRamAddr = 6'(idx); devRamWdata = d;
    @(negedge clk); devRamWe = 0;
  endtask

  task automatic bgStep(int pct, logic [15:0] rc);
    @(negedge clk); devBgValid = 1; devBgPct = 7'(pct); devBgRc = rc;
    @(negedge clk); devBgValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 and R6: reset state and capability
    expectRead(0, 0, "R1"); expectRead(4, 0, "R1"); expectRead(7, 0, "R1");
    expectRead(130, 0, "R1");
    expectRead(1, 32'h0000_0328, "R6");
    // R3: loads while clear
    hostWr(2, 32'hFFFF_1234); hostWr(3, 32'h0000_0008);
    hostWr(128, 32'h1111_2222); hostWr(129, 32'h3333_4444);
    expectRead(2, 32'h1234, "R3"); expectRead(3, 8, "R3");
    // R1, R2: ring with interrupt enable
    hostWr(0, 32'h3); #1;
    chk(devCmdValid === 1'b1, "R2", "cmd valid after ring", 32'(devCmdValid), 1);
    chk(devOpcode === 16'h1234, "R3", "devOpcode", 32'(devOpcode), 32'h1234);
    @(negedge clk); #1;
    chk(devCmdValid === 1'b0, "R2", "cmd valid one cycle", 32'(devCmdValid), 0);
    expectRead(0, 3, "R1");
    // R3: lockout
    hostWr(2, 32'hDEAD); hostWr(128, 32'h0BAD_0BAD); hostWr(0, 32'h0);
    expectRead(2, 32'h1234, "R3"); expectRead(128, 32'h1111_2222, "R3");
    expectRead(0, 3, "R1"); expectRead(7, 1, "R3");
    // R5, R4: device work and completion
    devRam(2, 32'hCAFE_F00D);
    devFinish(16'h0000, 21'd12);
    expectRead(0, 2, "R4"); expectRead(3, 12, "R4"); expectRead(130, 32'hCAFE_F00D, "R5");
    devRam(3, 32'h5555_AAAA);
    expectRead(131, 0, "R5");
    devFinish(16'h0042, 21'd99);
    expectRead(4, 0, "R4"); expectRead(3, 12, "R4");
    // R3: clear sticky flag
    hostWr(7, 32'h1); expectRead(7, 0, "R3");
    // collision: host control write and device completion at one edge
    hostWr(0, 32'h3);
    @(negedge clk); regWr = 1; regAddr = 0; regWdata = 0;
    devDone = 1; devRetCode = 16'h0005; devOutLen = 21'd4;
    @(negedge clk); regWr = 0; devDone = 0;
    expectRead(0, 2, "R4"); expectRead(7, 1, "R3"); expectRead(4, 5, "R4");
    hostWr(7, 32'h1);
    // R7, R8, R9: background command with interrupt
    hostWr(2, 32'h4400); hostWr(0, 32'h3);
    bgStep(100, 16'h9);  // no background active yet: ignored
    devFinish(16'h0001, 21'd0);
    expectRead(5, 32'h0000_4400, "R7"); expectRead(6, 0, "R7");
    bgStep(50, 16'h0);
    expectRead(5, 32'h0032_4400, "R8");
    bgStep(120, 16'h7); #1;
    chk(bgIrq === 1'b1, "R9", "irq at 100", 32'(bgIrq), 1);
    expectRead(5, 32'h0064_4400, "R8"); expectRead(6, 7, "R8");
    bgStep(30, 16'h3);
    expectRead(5, 32'h0064_4400, "R8"); expectRead(6, 7, "R8");
    // R9: no interrupt when disabled
    hostWr(0, 32'h1); devFinish(16'h0001, 21'd0);
    bgStep(100, 16'h2); #1;
    chk(bgIrq === 1'b0, "R9", "no irq when disabled", 32'(bgIrq), 0);
    expectRead(6, 2, "R8");
    // R10: zero reads
    hostWr(191, 32'h7777_8888); expectRead(191, 32'h7777_8888, "R10");
    expectRead(192, 0, "R10"); expectRead(255, 0, "R10"); expectRead(100, 0, "R10");
    expectRead(8, 0, "R10");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL R1 watchdog expired actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule